// File: doc/BRIEF.md
# Boot Memory Remap Decoder

This block turns a bus address into one of a set of select lines: eight active-low static-memory chip selects, a DRAM select, and a select for an external master port. Each static select owns a 64 MB window. The windows sit back to back from 0x40000000 up to 0x5FFFFFFF. Any address that lands nowhere raises a decode-miss flag.

After reset the processor fetches its first instructions from address zero, and that address must then reach non-volatile memory. A remap flag is therefore set by reset. While the flag is set, the low boot window goes to the static select chosen by a 4-bit boot switch. One group of switch codes instead sends a wider low range to the external master port. Software clears the flag by writing a control bit. From then on the low region belongs to DRAM, and only another reset can turn remap back on.

The switch value is captured while reset is held and kept for the rest of the run. The decode result is registered, so it appears one cycle after the address strobe.

Top module: `boot_remap_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `remapActive` is 1, all `staticCsN` bits and `expCsN` are 1, and `dramSel`, `extMasterSel` and `decodeMiss` are 0.
- R2: An address A in 0x40000000..0x5FFFFFFF that no remap rule claims drives `staticCsN[(A-0x40000000)/0x04000000]` low in the cycle after the strobe.
- R3: With remap set and switch bit 3 equal to 0, an address below 0x04000000 drives low the static select whose number is switch bits 2:0. The reserved codes 0001 and 0011 are decoded the same way, to selects 1 and 3.
- R4: With remap set and switch bit 3 equal to 1, an address below 0x10000000 asserts `extMasterSel` and no static select.
- R5: An address below 0x40000000 that is not claimed by R3 or R4 asserts `dramSel`.
- R6: An address at or above 0x60000000 asserts only `decodeMiss`.
- R7: The outputs are registered. In the cycle after a cycle with `addrValid` high, exactly one of the eleven selects and flags is asserted. In the cycle after a cycle with `addrValid` low, none is asserted.
- R8: A write with `ctrlWrEn` high and `ctrlWrData` bit 0 equal to 1 clears `remapActive` from the next cycle on. A write with bit 0 equal to 0 leaves it unchanged. An access strobed in the same cycle as the clearing write is decoded with remap still set.
- R9: Once `remapActive` is cleared, it stays cleared until reset. A later write of 1 to bit 0 has no effect.
- R10: The switch value present when reset is released is held. Moving the switches afterwards does not change the decode.
- R11: `expCsN` is low exactly when `staticCsN[7]` is low, whether select 7 was reached by remap or by its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| addrIn | input | 32 | Bus address |
| addrValid | input | 1 | Address strobe |
| bootSwitch | input | 4 | Boot select switches, sampled during reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 32 | Control write data; bit 0 = 1 clears remap |
| staticCsN | output | 8 | Active-low static chip selects |
| expCsN | output | 1 | Active-low expansion select, follows select 7 |
| dramSel | output | 1 | DRAM select |
| extMasterSel | output | 1 | External master port select |
| decodeMiss | output | 1 | No target claimed the address |
| remapActive | output | 1 | Remap flag state |

## Verification
The assertions assume a synchronous reset held low for at least one clock edge. They also assume that `addrValid`, `addrIn` and the write port are stable around each rising edge. The bench drives all inputs on the falling edge and holds them for a full cycle, so every sampled value is settled. The switches are set before reset is asserted and stay fixed until reset is released. They are moved only afterwards, to exercise the hold behaviour. Because every address is a legal input, the stimulus sweeps window edges and the top of the address space without any range restriction.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;
  parameter int BR_NUM_CS = 8;
  localparam int BR_IDX_W = $clog2(BR_NUM_CS);
  localparam int BR_SW_W = BR_IDX_W + 1;

  // Strobes from the control half to the datapath
  typedef struct packed {
    logic                remapOn;
    logic                extBoot;
    logic [BR_IDX_W-1:0] bootIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
  import boot_remap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [BR_SW_W-1:0] bootSwitch,
  input  logic               clrReq,
  output ctrlStrobes_t       strobes
);
  logic               remapQ;
  logic [BR_SW_W-1:0] swQ;

  // The switch value follows the pins while reset is held and freezes at release
  always_ff @(posedge clk) begin
    if (!rstN) begin
      remapQ <= 1'b1;
      swQ    <= bootSwitch;
    end else if (clrReq) begin
      remapQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.remapOn = remapQ;
    strobes.extBoot = swQ[BR_SW_W-1];
    strobes.bootIdx = swQ[BR_IDX_W-1:0];
  end
endmodule

// File: rtl/boot_remap_datapath.sv
module boot_remap_datapath
  import boot_remap_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                NUM_CS      = BR_NUM_CS,
  parameter int                WIN_BITS    = 26,
  parameter int                EXT_BITS    = 28,
  parameter logic [ADDR_W-1:0] STATIC_BASE = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              addrValid,
  input  ctrlStrobes_t      strobes,
  output logic [NUM_CS-1:0] staticCsN,
  output logic              dramSel,
  output logic              extMasterSel,
  output logic              decodeMiss
);
  localparam int IDX_W = BR_IDX_W;
  localparam logic [ADDR_W:0] BASE_X = {1'b0, STATIC_BASE};
  localparam logic [ADDR_W:0] END_X  = BASE_X + ((ADDR_W+1)'(NUM_CS) << WIN_BITS);

  logic [ADDR_W:0]   addrX;
  logic              inStatic, inLow, inBoot, inExt;
  logic              hitExt, hitBoot, hitStatic, hitDram, hitMiss;
  logic [IDX_W-1:0]  selIdx;
  logic [NUM_CS-1:0] csHit;

  always_comb begin
    addrX     = {1'b0, addrIn};
    inStatic  = (addrX >= BASE_X) && (addrX < END_X);
    inLow     = addrX < BASE_X;
    inBoot    = (addrIn >> WIN_BITS) == '0;
    inExt     = (addrIn >> EXT_BITS) == '0;
    hitExt    = strobes.remapOn && strobes.extBoot && inExt;
    hitBoot   = strobes.remapOn && !strobes.extBoot && inBoot;
    // The static region base is aligned to its total size, so the window number is an address slice
    selIdx    = hitBoot ? strobes.bootIdx : addrIn[WIN_BITS +: IDX_W];
    hitStatic = !hitExt && (hitBoot || inStatic);
    hitDram   = !hitExt && !hitBoot && inLow;
    hitMiss   = !hitExt && !hitStatic && !hitDram;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csHit[i] = hitStatic && (selIdx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN || !addrValid) begin
      staticCsN    <= '1;
      dramSel      <= 1'b0;
      extMasterSel <= 1'b0;
      decodeMiss   <= 1'b0;
    end else begin
      staticCsN    <= ~csHit;
      dramSel      <= hitDram;
      extMasterSel <= hitExt;
      decodeMiss   <= hitMiss;
    end
  end
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import boot_remap_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                NUM_CS      = BR_NUM_CS,
  parameter int                WIN_BITS    = 26,
  parameter int                EXT_BITS    = 28,
  parameter logic [ADDR_W-1:0] STATIC_BASE = 32'h4000_0000,
  parameter int                CTRL_W      = 32,
  parameter int                CLR_BIT     = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               addrValid,
  input  logic [BR_SW_W-1:0] bootSwitch,
  input  logic               ctrlWrEn,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  output logic [NUM_CS-1:0]  staticCsN,
  output logic               expCsN,
  output logic               dramSel,
  output logic               extMasterSel,
  output logic               decodeMiss,
  output logic               remapActive
);
  ctrlStrobes_t strobes;
  logic         clrReq;
  logic         unusedWrBits;

  assign clrReq       = ctrlWrEn && ctrlWrData[CLR_BIT];
  assign unusedWrBits = ^ctrlWrData;

  boot_remap_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bootSwitch(bootSwitch), .clrReq(clrReq), .strobes(strobes)
  );

  boot_remap_datapath #(
    .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .WIN_BITS(WIN_BITS),
    .EXT_BITS(EXT_BITS), .STATIC_BASE(STATIC_BASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrValid(addrValid), .strobes(strobes),
    .staticCsN(staticCsN), .dramSel(dramSel), .extMasterSel(extMasterSel),
    .decodeMiss(decodeMiss)
  );

  assign expCsN      = staticCsN[NUM_CS-1];
  assign remapActive = strobes.remapOn;
endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk #(
  parameter int                ADDR_W      = 32,
  parameter int                NUM_CS      = 8,
  parameter int                WIN_BITS    = 26,
  parameter logic [ADDR_W-1:0] STATIC_BASE = 32'h4000_0000,
  parameter int                CTRL_W      = 32,
  parameter int                CLR_BIT     = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              addrValid,
  input logic              ctrlWrEn,
  input logic [CTRL_W-1:0] ctrlWrData,
  input logic [NUM_CS-1:0] staticCsN,
  input logic              expCsN,
  input logic              dramSel,
  input logic              extMasterSel,
  input logic              decodeMiss,
  input logic              remapActive
);
  localparam logic [ADDR_W:0] BASE_X = {1'b0, STATIC_BASE};
  localparam logic [ADDR_W:0] END_X  = BASE_X + ((ADDR_W+1)'(NUM_CS) << WIN_BITS);
  localparam logic [ADDR_W:0] TOP_WIN = END_X - ((ADDR_W+1)'(1) << WIN_BITS);

  logic [ADDR_W:0] addrX;
  assign addrX = {1'b0, addrIn};

  // R7
  one_hot_after_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> $countones({~staticCsN, dramSel, extMasterSel, decodeMiss}) == 1);

  // R7
  idle_after_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> (&staticCsN && !dramSel && !extMasterSel && !decodeMiss));

  // R6
  high_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && addrX >= END_X) |=> decodeMiss);

  // R11
  top_window_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !remapActive && addrX >= TOP_WIN && addrX < END_X) |=> !expCsN);

  // R8
  remap_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrData[CLR_BIT]) |=> !remapActive);

  // R9
  remap_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !remapActive |=> !remapActive);

  // R4
  ext_needs_remap_chk: assert property (@(posedge clk) disable iff (!rstN)
    extMasterSel |-> $past(remapActive));
endmodule

bind boot_remap_decoder boot_remap_chk #(
  .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .WIN_BITS(WIN_BITS),
  .STATIC_BASE(STATIC_BASE), .CTRL_W(CTRL_W), .CLR_BIT(CLR_BIT)
) chk_i (
  .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrValid(addrValid),
  .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .staticCsN(staticCsN),
  .expCsN(expCsN), .dramSel(dramSel), .extMasterSel(extMasterSel),
  .decodeMiss(decodeMiss), .remapActive(remapActive)
);

// File: tb/boot_remap_decoder_tb_top.sv
module boot_remap_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] addrIn = '0;
  logic        addrValid = 1'b0;
  logic [3:0]  bootSwitch = '0;
  logic        ctrlWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic [7:0]  staticCsN;
  logic        expCsN, dramSel, extMasterSel, decodeMiss, remapActive;

  int checks = 0;
  int fails = 0;
  bit mRemap;
  bit [3:0] mSw;

  always #2 clk = ~clk;

  boot_remap_decoder dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrValid(addrValid),
    .bootSwitch(bootSwitch), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .staticCsN(staticCsN), .expCsN(expCsN), .dramSel(dramSel),
    .extMasterSel(extMasterSel), .decodeMiss(decodeMiss), .remapActive(remapActive)
  );

  // Reference: {csN[7:0], exp, dram, ext, miss}
  function automatic logic [11:0] refOut(longint a, bit v, bit rm, bit [3:0] sw);
    logic [7:0] cs = 8'hFF;
    bit d = 0, e = 0, m = 0;
    int n = -1;
    if (v) begin
      if (rm && sw[3] && a < 64'h1000_0000) e = 1;
      else if (rm && !sw[3] && a < 64'h0400_0000) n = int'(sw[2:0]);
      else if (a >= 64'h4000_0000 && a < 64'h6000_0000) n = int'((a - 64'h4000_0000) / 64'h0400_0000);
      else if (a < 64'h4000_0000) d = 1;
      else m = 1;
      if (n >= 0) cs[n] = 1'b0;
    end
    return {cs, cs[7], d, e, m};
  endfunction

  function automatic void compare(logic [11:0] expv, bit expRm, string tag);
    logic [11:0] act = {staticCsN, expCsN, dramSel, extMasterSel, decodeMiss};
    checks++;
    if (act !== expv || remapActive !== expRm) begin
      fails++;
      $display("FAIL %s: actual outs=%h remap=%b expected outs=%h remap=%b",
               tag, act, remapActive, expv, expRm);
    end
  endfunction

  task automatic step(input logic [31:0] a, input bit v, input bit we, input logic [31:0] wd,
                      input string tag);
    logic [11:0] expv;
    @(negedge clk);
    addrIn = a; addrValid = v; ctrlWrEn = we; ctrlWrData = wd;
    expv = refOut(longint'(a), v, mRemap, mSw);
    @(posedge clk);
    if (we && wd[0]) mRemap = 0;
    #1;
    compare(expv, mRemap, tag);
  endtask

  task automatic doReset(input logic [3:0] sw);
    @(negedge clk);
    rstN = 1'b0; bootSwitch = sw; addrValid = 0; ctrlWrEn = 0;
    repeat (3) @(posedge clk);
    #1;
    compare(refOut(0, 0, 1, sw), 1'b1, "R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    mRemap = 1; mSw = sw;
    step(32'h0, 0, 0, 0, "R1 after release");
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset(4'b0010);
    step(32'h0000_0000, 1, 0, 0, "R3 boot base");
    step(32'h03FF_FFFC, 1, 0, 0, "R3 boot top");
    step(32'h0400_0000, 1, 0, 0, "R5 above boot");
    step(32'h3FFF_FFFF, 1, 0, 0, "R5 low top");
    for (int n = 0; n < 8; n++)
      step(32'h4000_0000 + n * 32'h0400_0000 + 32'h100, 1, 0, 0, "R2 window");
    step(32'h5FFF_FFFF, 1, 0, 0, "R11 window7 end");
    step(32'h6000_0000, 1, 0, 0, "R6 miss edge");
    step(32'hFFFF_FFFF, 1, 0, 0, "R6 miss top");
    step(32'h0000_0000, 0, 0, 0, "R7 no strobe");
    step(32'h4000_0000, 1, 0, 0, "R7 back to back");
    @(negedge clk) bootSwitch = 4'b1000;
    step(32'h0000_0000, 1, 0, 0, "R10 switch moved");
    step(32'h0800_0000, 1, 0, 0, "R10 switch moved ext range");
    step(32'h0000_0000, 1, 1, 32'hFFFF_FFFE, "R8 bit0 zero");
    step(32'h0000_0000, 1, 1, 32'h1, "R8 clear same cycle");
    step(32'h0000_0000, 1, 0, 0, "R8 cleared goes dram");
    step(32'h0000_0000, 1, 1, 32'h1, "R9 second clear");
    step(32'h0000_0000, 0, 0, 0, "R9 stays clear");
    step(32'h5C00_0000, 1, 0, 0, "R11 window7 own");

    doReset(4'b1000);
    step(32'h0000_0000, 1, 0, 0, "R4 ext base");
    step(32'h0FFF_FFFF, 1, 0, 0, "R4 ext top");
    step(32'h1000_0000, 1, 0, 0, "R5 above ext");
    step(32'h4400_0000, 1, 0, 0, "R2 window under ext");
    step(32'h0, 1, 1, 32'h1, "R8 clear ext");
    step(32'h0, 1, 0, 0, "R5 ext cleared");

    doReset(4'b0111);
    step(32'h0000_1000, 1, 0, 0, "R11 boot to cs7");
    doReset(4'b0001);
    step(32'h0000_1000, 1, 0, 0, "R3 reserved code 1");
    doReset(4'b0011);
    step(32'h0000_1000, 1, 0, 0, "R3 reserved code 3");
    doReset(4'b1111);
    step(32'h0000_0040, 1, 0, 0, "R4 ext code 1111");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule